// File: doc/BRIEF.md
# Flash Operation Status Reporter

This block sits in the read path of an embedded flash macro. While the command sequencer runs a program or an erase, or holds an erase in suspension, it replaces the array data on the read bus with a status byte. Software polls that byte to see whether the operation is still running, whether it ran past its time limit, and whether the location it reads belongs to the sector under erase. The block holds two independent toggle bits. Bit 6 flips on every completed read while an embedded operation is busy. Bit 2 flips only on reads that fall inside the sector being erased or suspended. Bit 5 is a sticky flag that records an exceeded time limit. When no operation is active, the array data passes straight through.

The sequencer presents its state as a 3-bit code. A read is a synchronous strobe that is high for one or more clock cycles. Toggle bits change on the clock edge that first sees the strobe low again. Every bit of the status byte therefore holds steady for the whole of a read, and the next read sees the new value.

Top module: `flash_status_mux`

## Requirements
- R1: An active-low reset clears both toggle bits and the time-limit flag. With op_state at idle (3'd0), dout equals array_data and ready is 1 during reset.
- R2: In idle (op_state 3'd0, and any code above 3'd4), dout equals array_data and ready is 1. After an operation completes, reads return true array data.
- R3: In program (3'd1), dout[7] is the inverse of prog_d7, dout[6] is the Q6 toggle, dout[5] is the time-limit flag, dout[3] and dout[2] are 0, and ready is 0.
- R4: In erase (3'd2), dout[7] is 0, dout[6] is the Q6 toggle, dout[5] is the time-limit flag, dout[3] is 1, dout[2] is the Q2 toggle, and ready is 0.
- R5: The Q6 toggle inverts once per completed read (strobe falling) in program, erase or suspend-program, however long the strobe is held. It does not change in any other way while an operation is active.
- R6: The Q2 toggle inverts once per completed read only when op_state is erase or suspended and addr_in_erase is 1. Otherwise it holds.
- R7: In suspended (3'd3) with addr_in_erase at 1, dout[7] is 1, dout[6] is the Q6 toggle held steady across reads, dout[5] and dout[3] are 0, dout[2] is the Q2 toggle, and ready is 1.
- R8: In suspended with addr_in_erase at 0, dout equals array_data and ready is 1.
- R9: Suspend-program (3'd4) reports the same pattern as program: inverted prog_d7 on dout[7], the Q6 toggle, and ready 0.
- R10: time_fail sampled high in program, erase or suspend-program sets the flag shown on dout[5] from the next cycle. The flag stays set while an operation remains active, and the other bits keep their pattern. The flag is hidden (dout[5] is 0) in suspended. time_fail has no effect in idle.
- R11: A cycle in idle clears both toggle bits and the time-limit flag, so the next operation starts with dout[6], dout[5] and dout[2] at 0.
- R12: Whenever the status byte is shown, dout[4], dout[1], dout[0] and every bit above 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Sequencer state: 0 idle, 1 program, 2 erase, 3 suspended, 4 suspend-program |
| time_fail | input | 1 | Embedded operation has exceeded its time limit |
| addr_in_erase | input | 1 | Read address lies in the sector being erased or suspended |
| prog_d7 | input | 1 | Bit 7 of the datum being programmed |
| rd_stb | input | 1 | Read strobe, high for the duration of a read |
| array_data | input | DW | Data read from the array |
| dout | output | DW | Read data: array data or status byte |
| ready | output | 1 | 1 when no embedded operation is running |

## Verification
On every cycle, the assertions check the fixed parts of each state's pattern: the inverted bit 7 during program, the bit 3 marker during erase, and the in-sector marker during suspension. They also check that each toggle moves only on a qualifying read completion, that the time-limit flag stays set, that an idle cycle clears everything, and that the spare bits stay at zero. Only the bench scenarios show the observable sequences: Q6 alternating across consecutive reads, Q2 staying still for reads outside the sector, Q6 freezing while suspended and then resuming, a long strobe counting as a single read, and the return of array data once the operation ends.

// File: rtl/flash_status_mux.sv
module flash_status_mux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_state,
  input  logic          time_fail,
  input  logic          addr_in_erase,
  input  logic          prog_d7,
  input  logic          rd_stb,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dout,
  output logic          ready
);
  localparam logic [2:0] ST_PROG  = 3'd1;
  localparam logic [2:0] ST_ERASE = 3'd2;
  localparam logic [2:0] ST_SUSP  = 3'd3;
  localparam logic [2:0] ST_SPROG = 3'd4;

  wire is_prog  = (op_state == ST_PROG) || (op_state == ST_SPROG);
  wire is_erase = (op_state == ST_ERASE);
  wire is_susp  = (op_state == ST_SUSP);
  wire busy     = is_prog || is_erase;
  wire active   = busy || is_susp;

  logic rd_q, t6_q, t2_q, tout_q;
  wire  rd_fall = rd_q && !rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      t6_q   <= 1'b0;
      t2_q   <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (!active) begin
        t6_q   <= 1'b0;
        t2_q   <= 1'b0;
        tout_q <= 1'b0;
      end else begin
        if (rd_fall && busy)
          t6_q <= ~t6_q;
        if (rd_fall && (is_erase || is_susp) && addr_in_erase)
          t2_q <= ~t2_q;
        if (time_fail && busy)
          tout_q <= 1'b1;
      end
    end
  end

  logic [7:0]    stat;
  logic [DW-1:0] stat_w;

  always_comb begin
    stat = 8'h00;
    if (is_prog) begin
      stat[7] = ~prog_d7;
      stat[6] = t6_q;
      stat[5] = tout_q;
    end else if (is_erase) begin
      stat[6] = t6_q;
      stat[5] = tout_q;
      stat[3] = 1'b1;
      stat[2] = t2_q;
    end else if (is_susp) begin
      stat[7] = 1'b1;
      stat[6] = t6_q;
      stat[2] = t2_q;
    end
  end

  always_comb begin
    stat_w      = '0;
    stat_w[7:0] = stat;
  end

  wire show_array = !active || (is_susp && !addr_in_erase);

  assign dout  = show_array ? array_data : stat_w;
  assign ready = !busy;
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_state,
  input logic          addr_in_erase,
  input logic          prog_d7,
  input logic          rd_stb,
  input logic [DW-1:0] dout,
  input logic          ready,
  input logic          rd_q,
  input logic          t6_q,
  input logic          t2_q,
  input logic          tout_q
);
  wire c_prog   = (op_state == 3'd1) || (op_state == 3'd4);
  wire c_erase  = (op_state == 3'd2);
  wire c_susp   = (op_state == 3'd3);
  wire c_busy   = c_prog || c_erase;
  wire c_active = c_busy || c_susp;
  wire c_fall   = rd_q && !rd_stb;

  AST_PROG_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    c_prog |-> (dout[7] == !prog_d7) && !dout[3] && !dout[2] && !ready); // R3

  AST_ERASE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    c_erase |-> dout[3] && !dout[7] && !ready); // R4

  AST_Q6_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fall && c_busy) |=> (t6_q != $past(t6_q))); // R5

  AST_Q6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_active && !(c_fall && c_busy)) |=> $stable(t6_q)); // R5

  AST_Q2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_active && !(c_fall && addr_in_erase && (c_erase || c_susp))) |=> $stable(t2_q)); // R6

  AST_SUSP_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_susp && addr_in_erase) |-> dout[7] && !dout[5] && !dout[3] && ready); // R7

  AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_q && c_active) |=> tout_q); // R10

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !c_active |=> (!t6_q && !t2_q && !tout_q)); // R11

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy || (c_susp && addr_in_erase)) |-> (!dout[4] && dout[1:0] == 2'b00)); // R12
endmodule

bind flash_status_mux flash_status_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_state(op_state), .addr_in_erase(addr_in_erase),
  .prog_d7(prog_d7), .rd_stb(rd_stb), .dout(dout), .ready(ready),
  .rd_q(rd_q), .t6_q(t6_q), .t2_q(t2_q), .tout_q(tout_q)
);

// File: tb/flash_status_mux_tb.sv
module flash_status_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_state = 3'd0;
  logic       time_fail = 1'b0;
  logic       addr_in_erase = 1'b0;
  logic       prog_d7 = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] array_data = 8'hA5;
  logic [7:0] dout;
  logic       ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_status_mux #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .time_fail(time_fail),
    .addr_in_erase(addr_in_erase), .prog_d7(prog_d7), .rd_stb(rd_stb),
    .array_data(array_data), .dout(dout), .ready(ready)
  );

  // entry: {op[2:0], in_sector, d7, time_fail, do_read, exp_ready, exp_dout[7:0]}
  localparam int NV = 29;
  localparam logic [15:0] VEC [0:NV-1] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5}, // R2 read in idle
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R3 R12
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h40}, // R5 flipped
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80}, // R5 flipped back
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80}, // R5 no read, no flip
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R2 completion
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h08}, // R4 R11 starts clear
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h4C}, // R4 R6 both toggled
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h08}, // R6 outside read next
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h48}, // R6 Q2 held
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC0}, // R7
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC4}, // R7 Q6 steady, Q2 flip
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5}, // R8
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC0}, // R6 R8 outside read no effect
    {3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h40}, // R9
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80}, // R9 Q6 flipped
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08}, // R4 resumed
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h28}, // R10 erase timeout
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6C}, // R10 sticky
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC4}, // R10 hidden in suspend
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R11 clears
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R11 flag gone
    {3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20}, // R10 program timeout
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R2
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5}, // R10 ignored in idle
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80}, // R10 not latched
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R2
    {3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5}, // R2 unused code acts as idle
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80}  // R11 nothing carried over
  };

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dout actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: ready actual %b expected %b", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic sec);
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return sec ? "R7" : "R8";
      3'd4: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check8("R1", dout, 8'hA5);
    check1("R1", ready, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_state      = VEC[i][15:13];
      addr_in_erase = VEC[i][12];
      prog_d7       = VEC[i][11];
      time_fail     = VEC[i][10];
      @(negedge clk);
      time_fail = 1'b0;
      check8(tag_of(VEC[i][15:13], VEC[i][12]), dout, VEC[i][7:0]);
      check1(tag_of(VEC[i][15:13], VEC[i][12]), ready, VEC[i][8]);
      if (VEC[i][9]) begin
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
      end
    end

    // R5: long strobe counts once, output steady during the read
    @(negedge clk);
    op_state = 3'd0;
    @(negedge clk);
    op_state = 3'd1;
    prog_d7  = 1'b0;
    @(negedge clk);
    check8("R5", dout, 8'h80);
    rd_stb = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check8("R5", dout, 8'h80);
    end
    rd_stb = 1'b0;
    @(negedge clk);
    check8("R5", dout, 8'hC0);
    @(negedge clk);
    check8("R5", dout, 8'hC0);

    // R1: reset mid-operation clears the toggle
    rst_n = 1'b0;
    @(negedge clk);
    check8("R1", dout, 8'h80);
    check1("R1", ready, 1'b0);
    rst_n = 1'b1;

    // R2: different array value passes through in idle
    op_state   = 3'd0;
    array_data = 8'h3C;
    @(negedge clk);
    check8("R2", dout, 8'h3C);
    check1("R2", ready, 1'b1);

    // R8: outside-sector read in suspend follows array data
    op_state      = 3'd3;
    addr_in_erase = 1'b0;
    @(negedge clk);
    check8("R8", dout, 8'h3C);
    check1("R8", ready, 1'b1);

    finish_run();
  end
endmodule